// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Interrupt Masking

A single-channel asynchronous serial port that sits on a simple 32-bit register bus. Software writes a character into a one-deep transmit holding register. A shifter sends it as a fixed frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. A receiver finds the start bit on a synchronized input, checks it again at mid-bit, and samples each later bit at its centre. Every bit lasts as many clocks as the programmable divisor holds.

A status word keeps error flags that stay set until software writes the status register. A control word holds one interrupt enable for each status bit at the same position, plus a forced-break control and the RTS output. The CTS input is synchronized, and any change of its level is latched. One level-sensitive interrupt line is high whenever an enabled status bit is set. The parity flag and the end-of-packet flag are placeholders that always read zero, and the end-of-packet register reads as zero.

The transmitter runs a four-state machine. `TX_IDLE` moves to `TX_START` when the holding register is full and loads the shifter. `TX_START` moves to `TX_DATA` after one bit period. `TX_DATA` moves to `TX_STOP` after the eighth bit. `TX_STOP` returns to `TX_IDLE` after one period.

The receiver runs a five-state machine. `RX_IDLE` moves to `RX_START` on a low line. `RX_START` returns to `RX_IDLE` if the line is high again at half a period (a false start); otherwise it moves to `RX_DATA`. `RX_DATA` moves to `RX_STOP` after eight full-period samples. `RX_STOP` samples the stop bit one period later and moves to `RX_IDLE` if that sample is high, or to `RX_HOLD` if it is low. `RX_HOLD` waits for a high line and then returns to `RX_IDLE`.

Top module: `serial_port`

## Requirements
- R1: Register selection uses byte-address bits 4:2: 0 rx data, 1 tx data, 2 status, 3 control, 4 divisor, 5 end-of-packet. After reset, control reads 0, status reads 0x060 (bit5 shifter idle and bit6 tx ready set, CTS low), the divisor reads DIV_RESET, the end-of-packet register reads 0, txd is high and irq is low.
- R2: A write to tx data sends a frame on txd. The frame is a low start bit, data bits 0 to 7 in that order, then a high stop bit, and each bit lasts divisor clocks.
- R3: A tx data write while status bit6 (tx ready) is 0 sets status bit4 (tx overrun) and is discarded. A character already in the holding register is still sent.
- R4: A received character sets status bit7 (rx ready), and its value reads in bits 7:0 of rx data. Reading rx data clears bit7.
- R5: If a character completes while bit7 is still set, status bit3 (rx overrun) is set and the new character replaces the old one.
- R6: A low stop-bit sample sets status bit1 (framing error). The character is still delivered with bit7 set.
- R7: A line held low through a whole frame, stop bit included, sets status bit2 (break) and does not set bit7. The receiver rearms only after the line goes high.
- R8: Status bit8 is the OR of bits 0 to 4.
- R9: Any write to status clears bits 1, 2, 3, 4 and 10. Bits 5, 6, 7 and 11 keep following the hardware.
- R10: irq is high exactly when some bit in 0 to 8, 10 or 12 is set in both status and control. Control bits 9 and 11 never cause an interrupt.
- R11: While control bit9 is set, txd is held low.
- R12: The rts output follows control bit11. Status bit11 shows the CTS level after a two-flop synchronizer, and either edge of that synchronized level sets status bit10.
- R13: A divisor write changes the bit period of both the transmitter and the receiver, and the new value reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on rx data only) |
| bus_addr | input | 5 | Byte address; bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register selected by bus_addr |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| cts_in | input | 1 | Clear-to-send input, asynchronous |
| rts_out | output | 1 | Request-to-send output |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The bench builds the port with a 16-bit divisor and DIV_RESET of 8. Each frame then takes only 80 clocks, so overrun, back-to-back and break cases all fit in a short run. Partway through, the bench programs an odd divisor of 11. That makes the half-period truncation in start-bit checking matter, and a wrong bit period would show up as drift across the nine samples that follow.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

    // register selects, taken from byte address bits 4:2
    typedef enum logic [2:0] {
        SEL_RXD  = 3'd0,
        SEL_TXD  = 3'd1,
        SEL_STAT = 3'd2,
        SEL_CTRL = 3'd3,
        SEL_DIV  = 3'd4,
        SEL_EOP  = 3'd5,
        SEL_RSV6 = 3'd6,
        SEL_RSV7 = 3'd7
    } reg_sel_e;

    localparam int FLAG_W = 13;

    // status / control bit positions (enable bit i gates status bit i)
    localparam int B_PAR   = 0;
    localparam int B_FRM   = 1;
    localparam int B_BRK   = 2;
    localparam int B_ROVR  = 3;
    localparam int B_TOVR  = 4;
    localparam int B_IDLE  = 5;
    localparam int B_TRDY  = 6;
    localparam int B_RRDY  = 7;
    localparam int B_EXC   = 8;
    localparam int B_FBRK  = 9;
    localparam int B_CTSCH = 10;
    localparam int B_CTS   = 11;
    localparam int B_PKT   = 12;

    localparam logic [FLAG_W-1:0] IRQ_MASK = 13'h15FF;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

endpackage

// File: rtl/sp_tx.sv
module sp_tx
    import serial_port_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [DIV_W-1:0]  divisor,
    output logic              line,
    output logic              ready,
    output logic              idle
);

    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    tx_state_e          state, nxt;
    logic [DATA_W-1:0]  hold, shreg;
    logic               hold_v;
    logic [DIV_W-1:0]   cnt;
    logic [BIT_W-1:0]   bitn;
    logic               tick;

    assign tick = ({1'b0, cnt} + 1'b1) >= {1'b0, divisor};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (hold_v) nxt = TX_START;
            TX_START: if (tick) nxt = TX_DATA;
            TX_DATA:  if (tick && bitn == LAST_BIT) nxt = TX_STOP;
            TX_STOP:  if (tick) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold   <= '0;
            hold_v <= 1'b0;
            shreg  <= '0;
            cnt    <= '0;
            bitn   <= '0;
        end else begin
            if (load) begin
                hold   <= load_data;
                hold_v <= 1'b1;
            end
            if (state == TX_IDLE) begin
                cnt  <= '0;
                bitn <= '0;
                if (hold_v) begin
                    shreg  <= hold;
                    hold_v <= 1'b0;
                end
            end else if (tick) begin
                cnt <= '0;
                if (state == TX_DATA) begin
                    shreg <= {1'b0, shreg[DATA_W-1:1]};
                    bitn  <= bitn + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_START: line = 1'b0;
            TX_DATA:  line = shreg[0];
            default:  line = 1'b1;
        endcase
        ready = !hold_v;
        idle  = (state == TX_IDLE);
    end

endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import serial_port_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic [DIV_W-1:0]  divisor,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              frame_err,
    output logic              brk
);

    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    rx_state_e          state, nxt;
    logic               s1, s2;
    logic [DIV_W-1:0]   cnt;
    logic [BIT_W-1:0]   bitn;
    logic [DATA_W-1:0]  shreg;
    logic               tick_full, tick_half;

    assign tick_full = ({1'b0, cnt} + 1'b1) >= {1'b0, divisor};
    assign tick_half = ({1'b0, cnt} + 1'b1) >= {2'b0, divisor[DIV_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (!s2) nxt = RX_START;
            RX_START: if (tick_half) nxt = s2 ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick_full && bitn == LAST_BIT) nxt = RX_STOP;
            RX_STOP:  if (tick_full) nxt = s2 ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (s2) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else begin
            if (state != nxt) cnt <= '0;
            else if ((state == RX_START && tick_half) ||
                     (state != RX_START && tick_full)) cnt <= '0;
            else cnt <= cnt + 1'b1;

            if (state == RX_START) bitn <= '0;
            if (state == RX_DATA && tick_full) begin
                shreg <= {s2, shreg[DATA_W-1:1]};
                bitn  <= bitn + 1'b1;
            end
        end
    end

    always_comb begin
        done      = (state == RX_STOP) && tick_full;
        data      = shreg;
        frame_err = !s2;
        brk       = !s2 && (shreg == '0);
    end

endmodule

// File: rtl/serial_port.sv
module serial_port
    import serial_port_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rxd,
    output logic        txd,
    input  logic        cts_in,
    output logic        rts_out,
    output logic        irq
);

    localparam int DATA_W = 8;

    reg_sel_e           sel;
    logic               wr_tx, wr_stat, wr_ctrl, wr_div, rd_rx;
    logic [FLAG_W-1:0]  ctrl_q, status_w;
    logic [DIV_W-1:0]   div_q;
    logic [DATA_W-1:0]  rx_q;
    logic               frm_q, brk_q, rovr_q, tovr_q, ctsch_q, rrdy_q;
    logic               c1, c2, c3, cts_edge;
    logic               tx_line, tx_ready, tx_idle;
    logic               rx_done, rx_ferr, rx_brk;
    logic [DATA_W-1:0]  rx_byte;
    logic [31:DIV_W]    unused_wdata;
    logic [1:0]         unused_addr;

    assign unused_wdata = bus_wdata[31:DIV_W];
    assign unused_addr  = bus_addr[1:0];

    assign sel     = reg_sel_e'(bus_addr[4:2]);
    assign wr_tx   = bus_wr && sel == SEL_TXD;
    assign wr_stat = bus_wr && sel == SEL_STAT;
    assign wr_ctrl = bus_wr && sel == SEL_CTRL;
    assign wr_div  = bus_wr && sel == SEL_DIV;
    assign rd_rx   = bus_rd && sel == SEL_RXD;

    sp_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_tx && tx_ready),
        .load_data (bus_wdata[DATA_W-1:0]),
        .divisor   (div_q),
        .line      (tx_line),
        .ready     (tx_ready),
        .idle      (tx_idle)
    );

    sp_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .divisor   (div_q),
        .done      (rx_done),
        .data      (rx_byte),
        .frame_err (rx_ferr),
        .brk       (rx_brk)
    );

    assign cts_edge = c2 ^ c3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            div_q   <= DIV_W'(DIV_RESET);
            rx_q    <= '0;
            frm_q   <= 1'b0;
            brk_q   <= 1'b0;
            rovr_q  <= 1'b0;
            tovr_q  <= 1'b0;
            ctsch_q <= 1'b0;
            rrdy_q  <= 1'b0;
            c1      <= 1'b0;
            c2      <= 1'b0;
            c3      <= 1'b0;
        end else begin
            c1 <= cts_in;
            c2 <= c1;
            c3 <= c2;
            if (wr_ctrl) ctrl_q <= bus_wdata[FLAG_W-1:0];
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
            // clear first so that a same-cycle event wins
            if (wr_stat) begin
                frm_q   <= 1'b0;
                brk_q   <= 1'b0;
                rovr_q  <= 1'b0;
                tovr_q  <= 1'b0;
                ctsch_q <= 1'b0;
            end
            if (wr_tx && !tx_ready) tovr_q <= 1'b1;
            if (cts_edge) ctsch_q <= 1'b1;
            if (rx_done) begin
                if (rx_brk) begin
                    brk_q <= 1'b1;
                end else begin
                    rx_q   <= rx_byte;
                    rrdy_q <= 1'b1;
                    if (rrdy_q && !rd_rx) rovr_q <= 1'b1;
                    if (rx_ferr) frm_q <= 1'b1;
                end
            end
            if (rd_rx && !(rx_done && !rx_brk)) rrdy_q <= 1'b0;
        end
    end

    always_comb begin
        status_w          = '0;
        status_w[B_PAR]   = 1'b0;
        status_w[B_FRM]   = frm_q;
        status_w[B_BRK]   = brk_q;
        status_w[B_ROVR]  = rovr_q;
        status_w[B_TOVR]  = tovr_q;
        status_w[B_IDLE]  = tx_idle;
        status_w[B_TRDY]  = tx_ready;
        status_w[B_RRDY]  = rrdy_q;
        status_w[B_EXC]   = frm_q | brk_q | rovr_q | tovr_q;
        status_w[B_CTSCH] = ctsch_q;
        status_w[B_CTS]   = c2;
        status_w[B_PKT]   = 1'b0;
    end

    always_comb begin
        unique case (sel)
            SEL_RXD:  bus_rdata = {{(32-DATA_W){1'b0}}, rx_q};
            SEL_STAT: bus_rdata = {{(32-FLAG_W){1'b0}}, status_w};
            SEL_CTRL: bus_rdata = {{(32-FLAG_W){1'b0}}, ctrl_q};
            SEL_DIV:  bus_rdata = {{(32-DIV_W){1'b0}}, div_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign txd     = ctrl_q[B_FBRK] ? 1'b0 : tx_line;
    assign rts_out = ctrl_q[B_CTS];
    assign irq     = |(status_w & ctrl_q & IRQ_MASK);

endmodule

// File: rtl/serial_port_chk.sv
module serial_port_chk
    import serial_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [4:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              txd,
    input logic              irq,
    input logic [FLAG_W-1:0] status,
    input logic              rx_done,
    input logic              cts_edge
);

    logic at_txd, at_rxd, at_stat, at_ctrl;
    assign at_txd  = bus_addr[4:2] == SEL_TXD;
    assign at_rxd  = bus_addr[4:2] == SEL_RXD;
    assign at_stat = bus_addr[4:2] == SEL_STAT;
    assign at_ctrl = bus_addr[4:2] == SEL_CTRL;

    assert_tx_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && at_txd && !status[B_TRDY] |=> status[B_TOVR]);

    assert_rx_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && at_rxd && !rx_done |=> !status[B_RRDY]);

    assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && at_stat && !rx_done && !cts_edge
        |=> (status[B_TOVR:B_FRM] == 4'b0) && !status[B_CTSCH]);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && at_ctrl && bus_wdata[FLAG_W-1:0] == '0 |=> !irq);

    assert_force_break_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && at_ctrl && bus_wdata[B_FBRK] |=> !txd);

    assert_cts_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cts_edge |=> status[B_CTSCH]);

endmodule

bind serial_port serial_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .txd       (txd),
    .irq       (irq),
    .status    (status_w),
    .rx_done   (rx_done),
    .cts_edge  (cts_edge)
);

// File: tb/serial_port_bench.sv
module serial_port_bench;

    localparam int DIV0 = 8;
    localparam logic [4:0] A_RXD = 5'd0, A_TXD = 5'd4, A_STAT = 5'd8,
                           A_CTRL = 5'd12, A_DIV = 5'd16, A_EOP = 5'd20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;
    logic        cts_in = 1'b0;
    logic        rts_out;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cur_div  = DIV0;

    always #4 clk = ~clk;

    serial_port #(.DIV_W(16), .DIV_RESET(DIV0)) u_serial_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .cts_in(cts_in), .rts_out(rts_out), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_lvl);
        @(negedge clk);
        rxd = 1'b0;
        repeat (cur_div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (cur_div) @(negedge clk);
        end
        rxd = stop_lvl;
        repeat (cur_div) @(negedge clk);
        rxd = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic capture_tx(output logic [7:0] b, output logic start_lvl, output logic stop_lvl);
        while (txd !== 1'b0) @(negedge clk);
        repeat (cur_div / 2) @(negedge clk);
        start_lvl = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (cur_div) @(negedge clk);
            b[i] = txd;
        end
        repeat (cur_div) @(negedge clk);
        stop_lvl = txd;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_CTRL, d);  check("R1 control reset", d, 32'h0);
        rd(A_STAT, d);  check("R1 status reset", d, 32'h060);
        rd(A_DIV, d);   check("R1 divisor reset", d, DIV0);
        rd(A_EOP, d);   check("R1 eop reads zero", d, 32'h0);
        check("R1 txd idle", {31'b0, txd}, 32'h1);
        check("R1 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_tx_frame;
        logic [7:0] b; logic s0, s1;
        wr(A_TXD, 32'hA5);
        capture_tx(b, s0, s1);
        check("R2 start bit", {31'b0, s0}, 32'h0);
        check("R2 data lsb first", {24'b0, b}, 32'hA5);
        check("R2 stop bit", {31'b0, s1}, 32'h1);
        repeat (cur_div) @(negedge clk);
    endtask

    task automatic t_tx_overrun;
        logic [7:0] ba, bb; logic s0, s1; logic [31:0] d;
        fork
            begin
                capture_tx(ba, s0, s1);
                capture_tx(bb, s0, s1);
            end
            begin
                wr(A_TXD, 32'h3C);
                repeat (3) @(negedge clk);
                wr(A_TXD, 32'h81);
                wr(A_TXD, 32'hFF);
                rd(A_STAT, d);
                check("R3 overrun flagged, holding full, R8 exception", d, 32'h110);
            end
        join
        check("R3 first frame", {24'b0, ba}, 32'h3C);
        check("R3 held char sent, overrun write dropped", {24'b0, bb}, 32'h81);
        repeat (2 * cur_div) @(negedge clk);
        rd(A_STAT, d);
        check("R3 idle again, no third frame", d, 32'h170);
        wr(A_STAT, 32'h0);
    endtask

    task automatic t_rx_byte;
        logic [31:0] d;
        send_rx(8'h3C, 1'b1);
        rd(A_STAT, d); check("R4 rx ready", d, 32'h0E0);
        rd(A_RXD, d);  check("R4 rx data", d, 32'h3C);
        rd(A_STAT, d); check("R4 read clears rx ready", d, 32'h060);
    endtask

    task automatic t_rx_overrun;
        logic [31:0] d;
        send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        rd(A_STAT, d); check("R5 rx overrun and R8 exception", d, 32'h1E8);
        rd(A_RXD, d);  check("R5 newest char kept", d, 32'h22);
        wr(A_STAT, 32'h0);
    endtask

    task automatic t_framing;
        logic [31:0] d;
        send_rx(8'h5A, 1'b0);
        rd(A_STAT, d); check("R6 framing error with rx ready, R8", d, 32'h1E2);
        rd(A_RXD, d);  check("R6 char delivered", d, 32'h5A);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); check("R9 status write clears sticky", d, 32'h060);
    endtask

    task automatic t_break_rx;
        logic [31:0] d;
        @(negedge clk);
        rxd = 1'b0;
        repeat (14 * cur_div) @(negedge clk);
        rxd = 1'b1;
        repeat (6) @(negedge clk);
        rd(A_STAT, d); check("R7 break flagged, no rx ready", d, 32'h164);
        wr(A_STAT, 32'h0);
        send_rx(8'h47, 1'b1);
        rd(A_RXD, d);  check("R7 receiver rearmed after break", d, 32'h47);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(A_CTRL, 32'h080);
        check("R10 no irq without rx ready", {31'b0, irq}, 32'h0);
        send_rx(8'h99, 1'b1);
        check("R10 irq on rx ready", {31'b0, irq}, 32'h1);
        rd(A_RXD, d);
        @(negedge clk);
        check("R10 irq drops after read", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h040);
        check("R10 irq on tx ready", {31'b0, irq}, 32'h1);
        cts_in = 1'b1;
        wr(A_CTRL, 32'h000);
        repeat (5) @(negedge clk);
        wr(A_STAT, 32'h0);
        wr(A_CTRL, 32'h800);
        check("R10 cts level bit not maskable", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h000);
        cts_in = 1'b0;
        repeat (5) @(negedge clk);
        wr(A_STAT, 32'h0);
    endtask

    task automatic t_force_break;
        wr(A_CTRL, 32'h200);
        check("R11 txd held low", {31'b0, txd}, 32'h0);
        repeat (20) @(negedge clk);
        check("R11 txd still low", {31'b0, txd}, 32'h0);
        wr(A_CTRL, 32'h000);
        check("R11 txd released", {31'b0, txd}, 32'h1);
    endtask

    task automatic t_modem;
        logic [31:0] d;
        wr(A_CTRL, 32'hC00);
        check("R12 rts follows control", {31'b0, rts_out}, 32'h1);
        cts_in = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_STAT, d); check("R12 cts level and rise latched", d, 32'hC60);
        check("R12 irq on cts change", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); check("R12 change cleared, level kept", d, 32'h860);
        cts_in = 1'b0;
        repeat (5) @(negedge clk);
        rd(A_STAT, d); check("R12 fall latched", d, 32'h460);
        wr(A_CTRL, 32'h000);
        check("R12 rts low", {31'b0, rts_out}, 32'h0);
        wr(A_STAT, 32'h0);
    endtask

    task automatic t_divisor;
        logic [31:0] d; logic [7:0] b; logic s0, s1;
        wr(A_DIV, 32'd11);
        cur_div = 11;
        rd(A_DIV, d); check("R13 divisor readback", d, 32'd11);
        wr(A_TXD, 32'hC3);
        capture_tx(b, s0, s1);
        check("R13 tx at new rate", {22'b0, s0, b, s1}, {22'b0, 1'b0, 8'hC3, 1'b1});
        repeat (cur_div) @(negedge clk);
        send_rx(8'h96, 1'b1);
        rd(A_RXD, d); check("R13 rx at new rate", d, 32'h96);
        wr(A_DIV, DIV0);
        cur_div = DIV0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_tx_frame();
        t_tx_overrun();
        t_rx_byte();
        t_rx_overrun();
        t_framing();
        t_break_rx();
        t_irq();
        t_force_break();
        t_modem();
        t_divisor();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule